// File: doc/BRIEF.md
# Deferred-Load DAC Latch Controller

This block sits between a register write port and a bank of DAC channels. Each channel keeps a data register, which software writes, and an output latch, which drives the converter. A per-channel mode bit picks when the latch follows the data register. In immediate mode the latch copies the data register one cycle after a write. In deferred mode the latch waits for a global load command, so that several channels can change together on the same clock edge.

Each channel keeps a pending flag, which shows that its data register holds a value not yet moved to the latch. A global load moves data only for deferred channels that have a pending write. Channels that were not written since the last load are left alone. The load bit in the control register clears itself once the transfer has happened. The analog converter and any output filtering lie outside this block.

Top module: `dac_latch_ctrl`

## Requirements
- R1: After synchronous reset every output latch reads 0, every pending flag is clear, the load flag is 0, and every channel is in immediate mode.
- R2: Register addresses are decoded as follows. Addresses 0 to NUM_CH-1 select the channel data registers. Address NUM_CH is the mode register, where bit i = 1 puts channel i in deferred mode. Address NUM_CH+1 is the control register, where bit 0 = 1 requests a global load. With the defaults, a write to channel 3 (address 3) reaches only channel 3.
- R3: A write to an immediate-mode channel sets its pending flag at the write edge. The next rising edge copies the value to the channel output and clears the flag.
- R4: A deferred-mode channel keeps its output unchanged, and its pending flag set, until a global load takes place.
- R5: Writing 1 to control bit 0 sets the load flag at that edge. At the following edge every deferred channel with a pending write copies its data register to its output, with no further delay stage, and its pending flag clears.
- R6: A global load does not reload a channel that has no pending write. Its output and its clear pending flag remain unchanged.
- R7: The load flag clears itself on the edge after it was set. Writing 0 to control bit 0 leaves the load flag at 0.
- R8: If a channel is written on the same edge that a global load takes effect, that channel is not latched, its new value stays pending, and the next load transfers it.
- R9: When a deferred channel that has a pending write is switched to immediate mode, its output takes the pending value on the edge after the mode write.
- R10: A write to an address above NUM_CH+1 changes no output, no pending flag and no load flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| dac_out | output | NUM_CH*DATA_W | Output latches; channel i occupies bits [i*DATA_W +: DATA_W] |
| pend_out | output | NUM_CH | Pending flag of each channel |
| load_busy | output | 1 | Global load flag, high for the cycle in which a load is waiting |

## Verification
On every cycle the assertions check several rules. A deferred channel's latch holds between loads. A channel with no pending write never changes its latch. An immediate channel transfers and clears its pending flag on the next edge. A write always leaves the channel pending. The load flag drops by itself, and no deferred pending channel that was not written stays pending after a load. Other properties need the bench's ordered scenarios to show them: the address decode, the reset values, a write and a load landing on the same edge and then completing on a later load, a switch from deferred to immediate mode releasing a pending value, and writes to unmapped addresses leaving everything untouched.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;

    // Register target selected by a write address
    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_MODE,
        SEL_CTRL
    } sel_e;

    // Bit of the control register that requests a global load
    localparam int LOAD_BIT = 0;

    // Per-channel control view, driven by the top into each channel
    typedef struct packed {
        logic we;
        logic deferred;
        logic load;
    } ch_ctl_t;

    function automatic sel_e classify(input int unsigned addr, input int unsigned nch);
        if (addr < nch)
            return SEL_DATA;
        else if (addr == nch)
            return SEL_MODE;
        else if (addr == nch + 1)
            return SEL_CTRL;
        else
            return SEL_NONE;
    endfunction

endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
    import dac_latch_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NUM_CH-1:0] data_we,
    output logic              mode_we,
    output logic              ctrl_we
);

    sel_e sel;

    always_comb begin
        sel     = classify(int'(wr_addr), NUM_CH);
        mode_we = wr_en && (sel == SEL_MODE);
        ctrl_we = wr_en && (sel == SEL_CTRL);
        for (int i = 0; i < NUM_CH; i++) begin
            data_we[i] = wr_en && (sel == SEL_DATA) && (int'(wr_addr) == i);
        end
    end

endmodule

// File: rtl/dac_channel.sv
module dac_channel
    import dac_latch_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_ctl_t           ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] latch_out,
    output logic              pend_out
);

    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] latch_q;
    logic              pend_q;
    logic              xfer;

    // A transfer needs a pending value and no write on the same edge
    always_comb begin
        xfer = pend_q && !ctl.we && (ctl.deferred ? ctl.load : 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            latch_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (ctl.we)
                data_q <= wdata;
            if (xfer)
                latch_q <= data_q;
            pend_q <= ctl.we || (pend_q && !xfer);
        end
    end

    assign latch_out = latch_q;
    assign pend_out  = pend_q;

    // R4: a deferred latch holds unless a load is active
    a_r4_deferred_holds: assert property (@(posedge clk) disable iff (rst)
        (ctl.deferred && !ctl.load) |=> $stable(latch_q));

    // R6: without a pending write the latch never reloads
    a_r6_idle_no_reload: assert property (@(posedge clk) disable iff (rst)
        !pend_q |=> $stable(latch_q));

    // R3: immediate channel transfers on the next edge
    a_r3_immediate_xfer: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !ctl.deferred && !ctl.we) |=> (!pend_q && latch_q == $past(data_q)));

    // R8: a write always leaves the channel pending
    a_r8_write_pending: assert property (@(posedge clk) disable iff (rst)
        ctl.we |=> pend_q);

endmodule

// File: rtl/dac_latch_ctrl.sv
module dac_latch_ctrl
    import dac_latch_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 12,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH*DATA_W-1:0] dac_out,
    output logic [NUM_CH-1:0]        pend_out,
    output logic                     load_busy
);

    localparam int MODE_W = NUM_CH;

    logic [NUM_CH-1:0] data_we;
    logic              mode_we;
    logic              ctrl_we;
    logic              load_req;
    logic [MODE_W-1:0] mode_q;
    logic              load_q;
    logic [NUM_CH-1:0] pend_vec;

    dac_wr_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .data_we (data_we),
        .mode_we (mode_we),
        .ctrl_we (ctrl_we)
    );

    assign load_req = ctrl_we && wr_data[LOAD_BIT];

    // Mode register and self-clearing load flag
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            load_q <= 1'b0;
        end else begin
            if (mode_we)
                mode_q <= wr_data[MODE_W-1:0];
            load_q <= load_req;
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            ch_ctl_t ctl;
            assign ctl.we       = data_we[g];
            assign ctl.deferred = mode_q[g];
            assign ctl.load     = load_q;

            dac_channel #(
                .DATA_W (DATA_W)
            ) u_ch (
                .clk       (clk),
                .rst       (rst),
                .ctl       (ctl),
                .wdata     (wr_data),
                .latch_out (dac_out[g*DATA_W +: DATA_W]),
                .pend_out  (pend_vec[g])
            );
        end
    endgenerate

    assign pend_out  = pend_vec;
    assign load_busy = load_q;

    // R7: the load flag drops unless a new load is requested
    a_r7_load_self_clears: assert property (@(posedge clk) disable iff (rst)
        (load_q && !load_req) |=> !load_q);

    // R5: a load clears every deferred pending channel not written that cycle
    a_r5_load_clears_pending: assert property (@(posedge clk) disable iff (rst)
        load_q |=> ((pend_vec & $past(mode_q & ~data_we & pend_vec)) == '0));

    // R2: the mode register takes the written bits
    a_r2_mode_write: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> (mode_q == $past(wr_data[MODE_W-1:0])));

endmodule

// File: tb/dac_latch_ctrl_test.sv
`timescale 1ns/1ps
module dac_latch_ctrl_test;

    localparam int NUM_CH = 4;
    localparam int DATA_W = 12;
    localparam int ADDR_W = 3;
    localparam int MODE_A = NUM_CH;
    localparam int CTRL_A = NUM_CH + 1;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     wr_en = 1'b0;
    logic [ADDR_W-1:0]        wr_addr = '0;
    logic [DATA_W-1:0]        wr_data = '0;
    logic [NUM_CH*DATA_W-1:0] dac_out;
    logic [NUM_CH-1:0]        pend_out;
    logic                     load_busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        string tag;
        int    kind;   // 0 output, 1 pending, 2 load flag
        int    ch;
        int    exp;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #4 clk = ~clk;

    dac_latch_ctrl #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dac_out   (dac_out),
        .pend_out  (pend_out),
        .load_busy (load_busy)
    );

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                int act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = int'(dac_out[it.ch*DATA_W +: DATA_W]);
                    1:       act = int'(pend_out[it.ch]);
                    default: act = int'(load_busy);
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d ch=%0d actual=%h expected=%h",
                             it.tag, it.kind, it.ch, act, it.exp);
                end
            end
        end
    end

    task automatic push(input string tag, input int kind, input int ch, input int exp);
        item_t it;
        it.tag = tag; it.kind = kind; it.ch = ch; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic flush();
        -> chk_ev;
        #2;
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic wr(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = DATA_W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int c = 0; c < NUM_CH; c++) begin
            push("R1", 0, c, 0);
            push("R1", 1, c, 0);
        end
        push("R1", 2, 0, 0);
        flush();

        // R3 immediate channel 0
        wr(0, 'h123);
        push("R3", 0, 0, 0);
        push("R3", 1, 0, 1);
        flush();
        tick();
        push("R3", 0, 0, 'h123);
        push("R3", 1, 0, 0);
        flush();

        // R4 deferred channels 1 and 2
        wr(MODE_A, 'b0110);
        wr(1, 'hAAA);
        wr(2, 'h555);
        tick(); tick();
        push("R4", 0, 1, 0);
        push("R4", 0, 2, 0);
        push("R4", 1, 1, 1);
        push("R4", 1, 2, 1);
        flush();

        // R5 / R7 global load
        wr(CTRL_A, 1);
        push("R7", 2, 0, 1);
        push("R5", 0, 1, 0);
        flush();
        tick();
        push("R5", 0, 1, 'hAAA);
        push("R5", 0, 2, 'h555);
        push("R5", 1, 1, 0);
        push("R5", 1, 2, 0);
        push("R7", 2, 0, 0);
        push("R6", 0, 0, 'h123);
        flush();

        // R7 writing 0 to load bit
        wr(CTRL_A, 0);
        push("R7", 2, 0, 0);
        flush();

        // R6 only the written channel reloads
        wr(1, 'h111);
        wr(CTRL_A, 1);
        tick();
        push("R6", 0, 1, 'h111);
        push("R6", 0, 2, 'h555);
        push("R6", 1, 2, 0);
        flush();

        // R8 write on the load edge
        wr(2, 'h321);
        wr(CTRL_A, 1);
        wr(2, 'h777);
        push("R8", 0, 2, 'h555);
        push("R8", 1, 2, 1);
        push("R8", 2, 0, 0);
        flush();
        wr(CTRL_A, 1);
        tick();
        push("R8", 0, 2, 'h777);
        push("R8", 1, 2, 0);
        flush();

        // R9 switch deferred to immediate with a pending value
        wr(1, 'h0F0);
        tick();
        push("R9", 0, 1, 'h111);
        flush();
        wr(MODE_A, 'b0100);
        tick();
        push("R9", 0, 1, 'h0F0);
        push("R9", 1, 1, 0);
        flush();

        // R10 unmapped addresses
        wr(6, 'hFFF);
        wr(7, 'hFFF);
        tick();
        push("R10", 0, 0, 'h123);
        push("R10", 0, 1, 'h0F0);
        push("R10", 0, 2, 'h777);
        push("R10", 0, 3, 0);
        for (int c = 0; c < NUM_CH; c++) push("R10", 1, c, 0);
        push("R10", 2, 0, 0);
        flush();

        // R2 decode: channel 3 address reaches channel 3 only
        wr(3, 'h9AB);
        tick();
        push("R2", 0, 3, 'h9AB);
        push("R2", 0, 0, 'h123);
        push("R2", 0, 1, 'h0F0);
        push("R2", 0, 2, 'h777);
        flush();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule